// File: doc/BRIEF.md
# Code Region Cycle Profiler

This block sits beside a compute kernel and measures how many clock cycles the kernel spends inside each of several code regions. The kernel brackets each region with a start command and an end command on a command stream. Each command names a region. The profiler keeps a free-running cycle counter. When a region opens, it records the count. When the region closes, it adds the elapsed cycles to that region's total. The totals grow across every pass through the same region and are never overwritten.

The kernel waits around each command, so the commands are strictly ordered against the work they bracket. When the kernel completes, it sends a finish command. The profiler then streams every region total back in bulk, in ascending region order, followed by one status word. A clear command resets all measurement state so that a new run can begin.

Top module: `region_profiler`

## Requirements
- R1: After reset, `res_valid` and `res_last` are low, `cmd_ready` is high, every region total is zero, and the status word is zero.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_op` selects the action: 0 opens a region, 1 closes a region, 2 requests the report, and 3 clears all state. When region r is closed after being opened, its total grows by the number of clock edges between the edge that accepted the open and the edge that accepted the close.
- R3: Repeated open/close pairs on the same region add to its total; a new interval never replaces an earlier one.
- R4: Opening a region that is already open restarts its interval from the new open command; the earlier open adds nothing.
- R5: A close on a region that is not open leaves every total and open flag unchanged. It sets a sticky error flag, which stays set until a clear or a reset.
- R6: A region total saturates at all ones (2^ACC_W − 1) instead of wrapping.
- R7: A report request produces NUM_REGIONS+1 words on `res_data`, one per cycle with `res_valid` high. The words start on the cycle after the accepting edge. They give the totals of regions 0, 1, … in ascending order, then the status word. `res_last` is high only with the status word. Reporting does not change the totals.
- R8: In the status word, bit 0 is the sticky error flag and bit 1+i is the open flag of region i. All other bits are zero.
- R9: While the report is streaming, `cmd_ready` is low, and any command presented is ignored.
- R10: A clear zeroes every region total, every open flag and the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Profiler can accept a command (low while reporting) |
| cmd_op | input | 2 | 0 open, 1 close, 2 report, 3 clear |
| cmd_region | input | $clog2(NUM_REGIONS) | Region index for open and close |
| res_valid | output | 1 | Result word valid |
| res_data | output | ACC_W | Region total or status word |
| res_last | output | 1 | Marks the status word, the final word of a report |

## Verification
On every cycle, the assertions check the framing of the report stream:

- a report begins right after it is requested;
- it runs without gaps until `res_last`;
- it stops right after `res_last`;
- it never overlaps with `cmd_ready`.

They also check that the error flag holds until a clear and drops on one.

The measured totals can be shown only by the bench's scenarios, which check them against cycle counts the bench tracks itself. These scenarios cover:

- interleaved and nested regions;
- restart of an open region;
- unmatched closes;
- saturation;
- commands presented during a report;
- clearing.

// File: rtl/region_profiler.sv
module region_profiler #(
  parameter int NUM_REGIONS = 16,
  parameter int ACC_W       = 64,
  localparam int RID_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int IDX_W = $clog2(NUM_REGIONS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [RID_W-1:0] cmd_region,
  output logic             res_valid,
  output logic [ACC_W-1:0] res_data,
  output logic             res_last
);
  localparam logic [1:0] OP_OPEN  = 2'd0;
  localparam logic [1:0] OP_CLOSE = 2'd1;
  localparam logic [1:0] OP_REPORT = 2'd2;
  localparam logic [1:0] OP_CLEAR = 2'd3;

  logic [ACC_W-1:0]       now_q;
  logic [ACC_W-1:0]       stamp_q [NUM_REGIONS];
  logic [ACC_W-1:0]       total_q [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] open_q;
  logic                   err_q;
  logic                   busy_q;
  logic [IDX_W-1:0]       idx_q;
  logic [ACC_W-1:0]       delta;
  logic [ACC_W:0]         sum;
  logic [ACC_W-1:0]       status_w;
  logic                   accept, hit;

  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && cmd_ready;
  assign hit       = accept && (int'(cmd_region) < NUM_REGIONS);
  assign delta     = now_q - stamp_q[cmd_region];
  assign sum       = {1'b0, total_q[cmd_region]} + {1'b0, delta};

  always_comb begin
    status_w = '0;
    status_w[0] = err_q;
    status_w[NUM_REGIONS:1] = open_q;
  end

  assign res_valid = busy_q;
  assign res_last  = busy_q && (idx_q == IDX_W'(NUM_REGIONS));
  assign res_data  = !busy_q ? '0 :
                     res_last ? status_w : total_q[idx_q[RID_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q  <= '0;
      open_q <= '0;
      err_q  <= 1'b0;
      busy_q <= 1'b0;
      idx_q  <= '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
        stamp_q[i] <= '0;
        total_q[i] <= '0;
      end
    end else begin
      now_q <= now_q + 1'b1;
      if (busy_q) begin
        idx_q <= idx_q + 1'b1;
        if (res_last) busy_q <= 1'b0;
      end
      if (accept) begin
        case (cmd_op)
          OP_OPEN: if (hit) begin
            stamp_q[cmd_region] <= now_q;
            open_q[cmd_region]  <= 1'b1;
          end
          OP_CLOSE: if (hit && open_q[cmd_region]) begin
            total_q[cmd_region] <= sum[ACC_W] ? '1 : sum[ACC_W-1:0];
            open_q[cmd_region]  <= 1'b0;
          end else begin
            err_q <= 1'b1;
          end
          OP_REPORT: begin
            busy_q <= 1'b1;
            idx_q  <= '0;
          end
          default: begin
            open_q <= '0;
            err_q  <= 1'b0;
            for (int i = 0; i < NUM_REGIONS; i++) total_q[i] <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/region_profiler_chk.sv
module region_profiler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       res_valid,
  input logic       res_last,
  input logic       err
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  a_r9_not_ready_in_report: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !cmd_ready);
  a_r7_last_in_report: assert property (@(posedge clk) disable iff (!rst_n)
    res_last |-> res_valid);
  a_r7_report_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd2) |=> res_valid);
  a_r7_report_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_last) |=> res_valid);
  a_r7_report_ends: assert property (@(posedge clk) disable iff (!rst_n)
    res_last |=> !res_valid);
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(acc && cmd_op == 2'd3)) |=> err);
  a_r10_clear_err: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd3) |=> !err);
endmodule

bind region_profiler region_profiler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .res_valid(res_valid), .res_last(res_last), .err(err_q)
);

// File: tb/test_region_profiler.sv
module test_region_profiler;
  localparam int N = 4;
  localparam int W = 12;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [1:0] cmd_region = '0;
  logic res_valid, res_last;
  logic [W-1:0] res_data;

  region_profiler #(.NUM_REGIONS(N), .ACC_W(W)) i_region_profiler (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_region(cmd_region), .res_valid(res_valid),
    .res_data(res_data), .res_last(res_last));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit done = 0;
  int m_tot [N];
  int m_stamp [N];
  bit m_open [N];
  bit m_err;

  // {op[1:0], region[1:0], idle cycles after[15:0]}
  localparam logic [19:0] VEC [12] = '{
    {2'd0, 2'd0, 16'd9}, {2'd1, 2'd0, 16'd2}, {2'd0, 2'd1, 16'd4},
    {2'd0, 2'd2, 16'd0}, {2'd1, 2'd1, 16'd6}, {2'd0, 2'd1, 16'd3},
    {2'd0, 2'd1, 16'd5}, {2'd1, 2'd1, 16'd1}, {2'd1, 2'd3, 16'd0},
    {2'd1, 2'd2, 16'd0}, {2'd0, 2'd3, 16'd0}, {2'd1, 2'd0, 16'd0}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int status_exp();
    int s = m_err ? 1 : 0;
    for (int i = 0; i < N; i++) if (m_open[i]) s |= 1 << (i + 1);
    return s;
  endfunction

  task automatic issue(input logic [1:0] op, input logic [1:0] r);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_region = r;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    case (op)
      2'd0: begin m_stamp[r] = cyc; m_open[r] = 1; end
      2'd1: if (m_open[r]) begin
              m_tot[r] = m_tot[r] + (cyc - m_stamp[r]);
              if (m_tot[r] > MAXV) m_tot[r] = MAXV;
              m_open[r] = 0;
            end else m_err = 1;
      2'd3: begin
              m_err = 0;
              for (int i = 0; i < N; i++) begin m_tot[i] = 0; m_open[i] = 0; end
            end
      default: ;
    endcase
  endtask

  task automatic report(input string req, input bit poke);
    issue(2'd2, 2'd0);
    for (int i = 0; i <= N; i++) begin
      @(negedge clk);
      if (poke) begin cmd_valid = 1'b1; cmd_op = 2'd0; cmd_region = 2'd2; end
      chk(res_valid && !cmd_ready && (res_last == (i == N)), {req, " R7 R9 framing"},
          {res_valid, cmd_ready, res_last}, {1'b1, 1'b0, i == N});
      chk(res_data == W'(i < N ? m_tot[i] : status_exp()), {req, " R7 R8 word"},
          res_data, i < N ? m_tot[i] : status_exp());
    end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(!res_valid && cmd_ready, {req, " R7 report over"}, {res_valid, cmd_ready}, 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_err = 0;
    for (int i = 0; i < N; i++) begin m_tot[i] = 0; m_stamp[i] = 0; m_open[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!res_valid && !res_last && cmd_ready, "R1 reset outputs",
        {res_valid, res_last, cmd_ready}, 1);
    rst_n = 1'b1;
    report("R1 reset totals", 0);

    for (int k = 0; k < 12; k++) begin
      issue(VEC[k][19:18], VEC[k][17:16]);
      repeat (int'(VEC[k][15:0])) @(posedge clk);
    end
    report("R2 R3 R4 R5 table", 0);

    // R9: commands presented during the report must be ignored
    report("R9 poke during report", 1);
    report("R9 after poke", 0);

    // R10: clear
    issue(2'd3, 2'd0);
    report("R10 clear", 0);

    // R6: saturation
    issue(2'd0, 2'd3); repeat (2999) @(posedge clk);
    issue(2'd1, 2'd3);
    issue(2'd0, 2'd3); repeat (1999) @(posedge clk);
    issue(2'd1, 2'd3);
    chk(m_tot[3] == MAXV, "R6 model saturated", m_tot[3], MAXV);
    report("R6 saturation", 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule